// File: doc/BRIEF.md
# Boot Vector and Mode Fetch Sequencer

This block runs once each time reset is released, before a CPU core fetches its first instruction. It can first hold off for a stabilization period of an oscillator. It then reads four bytes from the top of a 24-bit byte address space, one read at a time. Three of the bytes make up a 24-bit start address. Its upper byte goes to a bank output and its lower sixteen bits go to a program-counter output. The fourth byte is a mode byte, which the block passes on unchanged.

A single pin selects the source of the four reads. When the pin is high, the block reads from an internal ROM port. When it is low, the block reads from an external bus port. Both ports use the same protocol: a request with a held address, answered by a one-cycle acknowledge that carries the data. The acknowledge may come after any number of wait cycles.

When the last byte has arrived, the block drops its busy flag and raises a start pulse for one cycle. The core can then begin fetching at the start address. Asserting reset at any time abandons the sequence and clears every register. The sequence runs again from the beginning on the next release.

Top module: `mode_fetch_seq`

## Requirements
- R1: While reset is held low, busy is 1, start_pulse is 0, both request outputs are 0, and bank_out, pc_out and mode_out are all 0.
- R2: With osc_wait_en low, the first read request is visible after exactly one rising clock edge following reset release.
- R3: With osc_wait_en high, the first read request is visible after exactly WAIT_CYC+1 rising edges following reset release.
- R4: The reads go to byte addresses 0xFFFFDC, 0xFFFFDD, 0xFFFFDE and 0xFFFFDF, in that order. Only one read is outstanding at a time. The address stays stable on every wait cycle until the acknowledge arrives.
- R5: The byte read from 0xFFFFDC becomes pc_out[7:0]. The byte from 0xFFFFDD becomes pc_out[15:8]. The byte from 0xFFFFDE becomes bank_out[7:0].
- R6: The byte read from 0xFFFFDF becomes mode_out[7:0].
- R7: With int_vec_mode at 1, all reads use the ROM port. With int_vec_mode at 0, all reads use the external port. The request of the other port stays at 0, and an acknowledge on that port has no effect.
- R8: int_vec_mode is sampled only before the first read. A change while reads are in progress does not move the reads to the other port.
- R9: When the fourth byte is acknowledged, start_pulse is high for exactly one cycle. In that same cycle busy goes low, and no request is raised after that.
- R10: After start_pulse, bank_out, pc_out and mode_out do not change until the next reset, even if acknowledges or pin changes occur.
- R11: A reset in the middle of the sequence clears all outputs at once. After the next release the full four-read sequence runs again, starting at 0xFFFFDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_wait_en | input | 1 | 1 = hold off WAIT_CYC cycles before the first read |
| int_vec_mode | input | 1 | 1 = read from the internal ROM, 0 = read from the external bus |
| rom_req | output | 1 | Read request to the ROM port |
| rom_addr | output | 24 | Byte address to the ROM port |
| rom_ack | input | 1 | ROM data valid, one cycle |
| rom_rdata | input | 8 | ROM read data |
| ext_req | output | 1 | Read request to the external bus |
| ext_addr | output | 24 | Byte address to the external bus |
| ext_ack | input | 1 | External data valid, one cycle |
| ext_rdata | input | 8 | External read data |
| busy | output | 1 | High from reset until the sequence completes |
| start_pulse | output | 1 | One-cycle completion strobe |
| bank_out | output | 8 | Bank register (start address bits 23:16) |
| pc_out | output | 16 | Program counter (start address bits 15:0) |
| mode_out | output | 8 | Captured mode byte |

## Verification
The bench builds the block with WAIT_CYC set to 12 instead of the much larger default. This makes the enabled stabilization wait short enough to count edge by edge against WAIT_CYC+1, while the disabled case is checked against a single edge. The bench's bus responders insert zero, two or three wait cycles. This exercises address holding during stalls and one-at-a-time ordering on both ports. The small wait also lets the bench abort a sequence after two bytes, run it again with new data, and still run a post-completion phase in which stray acknowledges arrive.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  localparam int          ADDR_W    = 24;
  localparam int          BYTE_W    = 8;
  localparam int          N_SLOTS   = 4;
  localparam int          IDX_W     = $clog2(N_SLOTS);
  localparam int          PC_W      = 16;
  localparam int          BANK_W    = ADDR_W - PC_W;
  localparam int          MODE_SLOT = N_SLOTS - 1;
  localparam logic [ADDR_W-1:0] SLOT_BASE = 24'hFFFFDC;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_t;

  // Address of slot idx in the top-of-memory window
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [IDX_W-1:0] idx);
    return SLOT_BASE + ADDR_W'(idx);
  endfunction

  // True when an address lies inside the four-byte window
  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W] == SLOT_BASE[ADDR_W-1:IDX_W];
  endfunction

  // Low byte first: slot 0 -> bits 7:0, slot 1 -> 15:8, slot 2 -> 23:16
  function automatic logic [ADDR_W-1:0] join_start(input logic [BYTE_W-1:0] b2,
                                                   input logic [BYTE_W-1:0] b1,
                                                   input logic [BYTE_W-1:0] b0);
    return {b2, b1, b0};
  endfunction

  function automatic logic [BANK_W-1:0] bank_part(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PC_W];
  endfunction

  function automatic logic [PC_W-1:0] pc_part(input logic [ADDR_W-1:0] a);
    return a[PC_W-1:0];
  endfunction

endpackage

// File: rtl/mfs_osc_wait.sv
module mfs_osc_wait #(
  parameter int WAIT_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  output logic done
);
  localparam int CNT_W = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_CYC);

  logic [CNT_W-1:0] cnt;
  logic             at_zero;

  assign at_zero = (cnt == '0);
  assign done    = !en || at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= LOAD;
    else if (run && en && !at_zero)
      cnt <= cnt - 1'b1;
  end

  // The counter only falls while the wait is running and never wraps
  AST_WAIT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero |=> at_zero); // R3

endmodule

// File: rtl/mfs_bus_port.sv
module mfs_bus_port
  import mfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_int,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              ack,
  output logic [BYTE_W-1:0] rdata,
  output logic              rom_req,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic              rom_ack,
  input  logic [BYTE_W-1:0] rom_rdata,
  output logic              ext_req,
  output logic [ADDR_W-1:0] ext_addr,
  input  logic              ext_ack,
  input  logic [BYTE_W-1:0] ext_rdata
);

  always_comb begin
    rom_req  = req && sel_int;
    ext_req  = req && !sel_int;
    rom_addr = rom_req ? addr : '0;
    ext_addr = ext_req ? addr : '0;
    ack      = sel_int ? (rom_req && rom_ack) : (ext_req && ext_ack);
    rdata    = sel_int ? rom_rdata : ext_rdata;
  end

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_req && ext_req)); // R7

  AST_ROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && !rom_ack) |=> (rom_req && $stable(rom_addr))); // R4

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr))); // R4

  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req || ext_req) |-> in_window(rom_req ? rom_addr : ext_addr)); // R4

endmodule

// File: rtl/mfs_capture.sv
module mfs_capture
  import mfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] din,
  output logic [BANK_W-1:0] bank,
  output logic [PC_W-1:0]   pc,
  output logic [BYTE_W-1:0] mode
);

  logic [BYTE_W-1:0] slot_q [N_SLOTS];
  logic [ADDR_W-1:0] start_addr;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[i] <= '0;
      else if (cap_en && (idx == IDX_W'(i)))
        slot_q[i] <= din;
    end
  end

  assign start_addr = join_start(slot_q[2], slot_q[1], slot_q[0]);
  assign bank       = bank_part(start_addr);
  assign pc         = pc_part(start_addr);
  assign mode       = slot_q[MODE_SLOT];

endmodule

// File: rtl/mode_fetch_seq.sv
module mode_fetch_seq
  import mfs_pkg::*;
#(
  parameter int WAIT_CYC = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_wait_en,
  input  logic        int_vec_mode,
  output logic        rom_req,
  output logic [23:0] rom_addr,
  input  logic        rom_ack,
  input  logic [7:0]  rom_rdata,
  output logic        ext_req,
  output logic [23:0] ext_addr,
  input  logic        ext_ack,
  input  logic [7:0]  ext_rdata,
  output logic        busy,
  output logic        start_pulse,
  output logic [7:0]  bank_out,
  output logic [15:0] pc_out,
  output logic [7:0]  mode_out
);

  seq_state_t        state;
  logic [IDX_W-1:0]  idx;
  logic              sel_q;
  logic              start_q;

  // Named internal events
  logic              wait_done;
  logic              fetch_req;
  logic [ADDR_W-1:0] fetch_addr;
  logic              fetch_ack;
  logic [BYTE_W-1:0] fetch_data;
  logic              take_byte;
  logic              last_byte;

  assign fetch_req  = (state == ST_FETCH);
  assign fetch_addr = slot_addr(idx);
  assign take_byte  = fetch_req && fetch_ack;
  assign last_byte  = (idx == IDX_W'(N_SLOTS - 1));

  mfs_osc_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_WAIT),
    .en    (osc_wait_en),
    .done  (wait_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAIT;
      idx     <= '0;
      sel_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state)
        ST_WAIT: begin
          sel_q <= int_vec_mode;
          if (wait_done) state <= ST_FETCH;
        end
        ST_FETCH: begin
          if (take_byte) begin
            if (last_byte) begin
              state   <= ST_DONE;
              start_q <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  mfs_bus_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_int   (sel_q),
    .req       (fetch_req),
    .addr      (fetch_addr),
    .ack       (fetch_ack),
    .rdata     (fetch_data),
    .rom_req   (rom_req),
    .rom_addr  (rom_addr),
    .rom_ack   (rom_ack),
    .rom_rdata (rom_rdata),
    .ext_req   (ext_req),
    .ext_addr  (ext_addr),
    .ext_ack   (ext_ack),
    .ext_rdata (ext_rdata)
  );

  mfs_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (take_byte),
    .idx    (idx),
    .din    (fetch_data),
    .bank   (bank_out),
    .pc     (pc_out),
    .mode   (mode_out)
  );

  assign busy        = (state != ST_DONE);
  assign start_pulse = start_q;

  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> $past(wait_done)); // R3

  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte && !last_byte) |=> (fetch_req && fetch_addr == $past(fetch_addr) + 24'd1)); // R4

  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && $past(fetch_req)) |-> $stable(sel_q)); // R8

  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R9

  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> start_pulse); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(rom_req || ext_req)); // R9

  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable({bank_out, pc_out, mode_out})); // R10

endmodule

// File: tb/sim_mode_fetch_seq.sv
`timescale 1ns/1ps
module sim_mode_fetch_seq;

  localparam int W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_wait_en = 1'b0;
  logic        int_vec_mode = 1'b1;
  logic        rom_req, ext_req;
  logic [23:0] rom_addr, ext_addr;
  logic        rom_ack = 1'b0, ext_ack = 1'b0;
  logic [7:0]  rom_rdata = '0, ext_rdata = '0;
  logic        busy, start_pulse;
  logic [7:0]  bank_out, mode_out;
  logic [15:0] pc_out;

  always #4 clk = ~clk;

  mode_fetch_seq #(.WAIT_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_wait_en(osc_wait_en), .int_vec_mode(int_vec_mode),
    .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack), .rom_rdata(rom_rdata),
    .ext_req(ext_req), .ext_addr(ext_addr), .ext_ack(ext_ack), .ext_rdata(ext_rdata),
    .busy(busy), .start_pulse(start_pulse), .bank_out(bank_out), .pc_out(pc_out),
    .mode_out(mode_out)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  logic [7:0]  rom_mem [4];
  logic [7:0]  ext_mem [4];
  int          lat = 0;
  bit          rom_on = 1, ext_on = 1;
  logic [23:0] log_addr [16];
  int          log_port [16];
  int          nlog = 0;
  int          moved = 0;
  int          rom_w = 0, ext_w = 0;
  logic [23:0] rom_hold, ext_hold;
  int          start_cnt = 0, start_busy = 0, rom_seen = 0, ext_seen = 0, late_req = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ROM responder: acknowledges after lat wait cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      if (rom_on) rom_ack = 1'b0;
      rom_w = 0;
    end else if (rom_on) begin
      if (rom_ack) rom_ack = 1'b0;
      else if (rom_req) begin
        if (rom_w == 0) rom_hold = rom_addr;
        else if (rom_addr !== rom_hold) moved++;
        if (rom_w >= lat) begin
          rom_ack = 1'b1;
          rom_rdata = rom_mem[rom_addr[1:0]];
          log_addr[nlog] = rom_addr; log_port[nlog] = 1; nlog++;
          rom_w = 0;
        end else rom_w++;
      end else rom_w = 0;
    end
  end

  // External responder
  always @(negedge clk) begin
    if (!rst_n) begin
      if (ext_on) ext_ack = 1'b0;
      ext_w = 0;
    end else if (ext_on) begin
      if (ext_ack) ext_ack = 1'b0;
      else if (ext_req) begin
        if (ext_w == 0) ext_hold = ext_addr;
        else if (ext_addr !== ext_hold) moved++;
        if (ext_w >= lat) begin
          ext_ack = 1'b1;
          ext_rdata = ext_mem[ext_addr[1:0]];
          log_addr[nlog] = ext_addr; log_port[nlog] = 2; nlog++;
          ext_w = 0;
        end else ext_w++;
      end else ext_w = 0;
    end
  end

  // Observer away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (start_pulse) begin
        start_cnt++;
        if (busy) start_busy++;
      end
      if (rom_req) rom_seen++;
      if (ext_req) ext_seen++;
      if (!busy && !start_pulse && (rom_req || ext_req)) late_req++;
    end
  end

  task automatic clear_stats();
    nlog = 0; moved = 0; start_cnt = 0; start_busy = 0;
    rom_seen = 0; ext_seen = 0; late_req = 0;
  endtask

  // Hold reset, then release and count edges to the first request
  task automatic boot(input bit im, input bit we, input int l, output int cyc);
    @(negedge clk); rst_n = 1'b0;
    int_vec_mode = im; osc_wait_en = we; lat = l;
    repeat (3) @(negedge clk);
    clear_stats();
    rst_n = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!(rom_req || ext_req) && cyc < 100);
  endtask

  task automatic wait_start();
    int n = 0;
    while (!start_pulse && n < 500) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_log(input string tag, input int port);
    chk({tag, " count"}, nlog, 4);
    for (int i = 0; i < 4; i++) begin
      chk({tag, " order"}, log_addr[i], 24'hFFFFDC + i);
      chk({tag, " port"}, log_port[i], port);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 1);
    chk("R1 start", start_pulse, 0);
    chk("R1 req", {rom_req, ext_req}, 0);
    chk("R1 outs", {bank_out, pc_out, mode_out}, 0);
  endtask

  task automatic t_rom_nowait();
    int cyc;
    rom_mem = '{8'h34, 8'h12, 8'hAB, 8'h5A};
    ext_on = 0; ext_ack = 1'b1; ext_rdata = 8'hFF;
    boot(1'b1, 1'b0, 0, cyc);
    chk("R2 first req edge", cyc, 1);
    wait_start();
    check_log("R4 R7 rom", 1);
    chk("R5 pc", pc_out, 16'h1234);
    chk("R5 bank", bank_out, 8'hAB);
    chk("R6 mode", mode_out, 8'h5A);
    chk("R7 ext req idle", ext_seen, 0);
    chk("R9 start width", start_cnt, 1);
    chk("R9 busy at start", start_busy, 0);
    chk("R9 busy after", busy, 0);
    chk("R9 no late req", late_req, 0);
    ext_ack = 1'b0; ext_on = 1;
  endtask

  task automatic t_ext_wait();
    int cyc;
    ext_mem = '{8'hCD, 8'h89, 8'h07, 8'hC3};
    boot(1'b0, 1'b1, 3, cyc);
    chk("R3 first req edge", cyc, W + 1);
    int_vec_mode = 1'b1;
    wait_start();
    check_log("R4 R8 ext", 2);
    chk("R4 addr held", moved, 0);
    chk("R8 rom idle", rom_seen, 0);
    chk("R5 pc ext", pc_out, 16'h89CD);
    chk("R5 bank ext", bank_out, 8'h07);
    chk("R6 mode ext", mode_out, 8'hC3);
    chk("R9 start width ext", start_cnt, 1);
  endtask

  task automatic t_frozen();
    rom_on = 0; ext_on = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rom_ack = 1'b1; rom_rdata = 8'h11 * i; ext_ack = 1'b1; ext_rdata = 8'hEE;
      int_vec_mode = ~int_vec_mode;
    end
    @(negedge clk); rom_ack = 1'b0; ext_ack = 1'b0;
    @(negedge clk);
    chk("R10 pc held", pc_out, 16'h89CD);
    chk("R10 bank held", bank_out, 8'h07);
    chk("R10 mode held", mode_out, 8'hC3);
    chk("R10 no extra start", start_cnt, 1);
    chk("R10 busy low", busy, 0);
    rom_on = 1; ext_on = 1;
  endtask

  task automatic t_abort();
    int cyc, n;
    ext_mem = '{8'h10, 8'h20, 8'h30, 8'h40};
    boot(1'b0, 1'b0, 2, cyc);
    n = 0;
    while (nlog < 2 && n < 100) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 outs cleared", {bank_out, pc_out, mode_out}, 0);
    @(negedge clk);
    chk("R11 busy in reset", busy, 1);
    chk("R11 req off", {rom_req, ext_req}, 0);
    ext_mem = '{8'h01, 8'h02, 8'h03, 8'h04};
    clear_stats();
    @(negedge clk); rst_n = 1'b1;
    wait_start();
    check_log("R11 rerun", 2);
    chk("R11 pc", pc_out, 16'h0201);
    chk("R11 bank", bank_out, 8'h03);
    chk("R11 mode", mode_out, 8'h04);
  endtask

  initial begin
    rom_mem = '{default: 8'h00};
    ext_mem = '{default: 8'h00};
    t_reset_state();
    t_rom_nowait();
    t_ext_wait();
    t_frozen();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule